// File: doc/BRIEF.md
# Vector-Clock Epoch Identifier Unit

This block keeps the identifiers of one processor's speculative epochs as logical vector clocks: one counter per thread, packed into a single wide word. It tracks the identifier of the epoch that is running now, and a small indexed file of identifier slots. Cached lines name their owning epoch by slot index, not by the full identifier. Starting a new local epoch takes a free slot and writes the successor of the running identifier into it. An acquire-type synchronization folds a released identifier into the running epoch. Slots are handed back one at a time by an explicit free command.

A separate compare channel reads one slot and classifies it against an identifier that arrives with an incoming request. The result is equal, before, after or unordered. The unordered outcome raises a race flag, which the surrounding coherence logic uses to detect unsynchronized sharing. When a new epoch is requested and every slot is taken, the unit raises a stall and ignores the request. A free-slot count and a low-water flag, set against a threshold given at an input, let an outside reclaim engine start in time.

Top module: `vcid_unit`

## Requirements
- R1: After reset, cur_vld is 0, cur_id is all zeros, free_cnt equals the slot count (32), and stall and cmp_vld are 0.
- R2: A new-epoch command (op=1) accepted with a free slot updates the outputs one cycle later. cur_id is the previous identifier with the self_tid counter raised by one and all other counters unchanged. cur_slot is the lowest-numbered free slot, cur_vld is 1, and free_cnt drops by one. Counter k occupies bits [20k+19:20k].
- R3: A merge command (op=2) sets cur_id one cycle later to the per-counter maximum of cur_id and mrg_id, with the self_tid counter then raised by one. If cur_vld is 1, the slot of the running epoch is rewritten with that value.
- R4: A compare request produces cmp_vld one cycle later. cmp_rel then gives the relation of the stored slot identifier A to cmp_id B: 0 when all counters match, 1 when A is before B (every counter of A at most B's), 2 when A is after B, and 3 otherwise.
- R5: When the compared identifiers are unordered, cmp_rel is 3 and cmp_race is 1. In every other case cmp_race is 0.
- R6: While op=1 and no slot is free, stall is 1 in the same cycle, and cur_id, cur_slot and free_cnt are unchanged after the edge.
- R7: A free command (op=3) on an occupied slot raises free_cnt by one the next cycle, and the slot becomes eligible for allocation again. Freeing the running epoch's slot clears cur_vld. Freeing a slot that is already free changes nothing.
- R8: low_water is 1 exactly when free_cnt is below the lwm input.
- R9: After a sequence of merges, one per arriving barrier identifier, the running identifier compares as after every merged identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| self_tid | input | 2 | Index of this processor's thread counter |
| op | input | 2 | Command: 0 idle, 1 new epoch, 2 merge, 3 free slot |
| free_idx | input | 5 | Slot to release with the free command |
| mrg_id | input | 80 | Released identifier folded in by a merge |
| lwm | input | 6 | Low-water threshold for the free-slot count |
| cmp_req | input | 1 | Start a compare |
| cmp_idx | input | 5 | Slot holding the first compare operand |
| cmp_id | input | 80 | Second compare operand |
| stall | output | 1 | New-epoch request cannot be served |
| cur_id | output | 80 | Identifier of the running epoch |
| cur_slot | output | 5 | Slot of the running epoch |
| cur_vld | output | 1 | Running epoch holds a slot |
| free_cnt | output | 6 | Number of free slots |
| low_water | output | 1 | free_cnt below lwm |
| cmp_vld | output | 1 | Compare result valid |
| cmp_rel | output | 2 | Compare relation code |
| cmp_race | output | 1 | Compared identifiers are unordered |

## Verification
The registered results (cur_id, cur_slot, cur_vld, free_cnt, cmp_vld, cmp_rel and cmp_race) are due exactly one cycle after the command or compare request is driven. Each driver call records the expected value, tagged with the cycle count one edge later, and the monitor compares only when that due cycle arrives. It samples a couple of nanoseconds after the rising edge, and any entry that misses its cycle counts as a failure. stall and low_water depend only on the present inputs and state, so they are checked in the same cycle, one nanosecond after the inputs change on the falling edge.

// File: rtl/vcid_pkg.sv
package vcid_pkg;
    localparam int unsigned NTHR  = 4;
    localparam int unsigned CW    = 20;
    localparam int unsigned NSLOT = 32;
    localparam int unsigned IDW   = NTHR * CW;
    localparam int unsigned TW    = $clog2(NTHR);
    localparam int unsigned SW    = $clog2(NSLOT);
    localparam int unsigned CNTW  = SW + 1;

    typedef logic [IDW-1:0]  vcid_t;
    typedef logic [SW-1:0]   slot_t;
    typedef logic [CNTW-1:0] cnt_t;
    typedef logic [TW-1:0]   tid_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_NEW   = 2'd1,
        OP_MERGE = 2'd2,
        OP_FREE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        REL_EQ     = 2'd0,
        REL_BEFORE = 2'd1,
        REL_AFTER  = 2'd2,
        REL_UNORD  = 2'd3
    } rel_e;

    // Raise the counter of thread t by one.
    function automatic vcid_t vc_succ(vcid_t v, tid_t t);
        vcid_t r;
        r = v;
        for (int k = 0; k < int'(NTHR); k++) begin
            if (k == int'(t)) r[k*CW +: CW] = v[k*CW +: CW] + CW'(1);
        end
        return r;
    endfunction

    // Per-counter maximum, then successor on thread t.
    function automatic vcid_t vc_merge(vcid_t a, vcid_t b, tid_t t);
        vcid_t r;
        for (int k = 0; k < int'(NTHR); k++) begin
            r[k*CW +: CW] = (a[k*CW +: CW] > b[k*CW +: CW]) ? a[k*CW +: CW] : b[k*CW +: CW];
        end
        return vc_succ(r, t);
    endfunction

    // Relation of a to b (used by checks).
    function automatic rel_e vc_rel(vcid_t a, vcid_t b);
        logic all_le, all_ge;
        all_le = 1'b1;
        all_ge = 1'b1;
        for (int k = 0; k < int'(NTHR); k++) begin
            if (a[k*CW +: CW] > b[k*CW +: CW]) all_le = 1'b0;
            if (a[k*CW +: CW] < b[k*CW +: CW]) all_ge = 1'b0;
        end
        if (all_le && all_ge) return REL_EQ;
        if (all_le)           return REL_BEFORE;
        if (all_ge)           return REL_AFTER;
        return REL_UNORD;
    endfunction
endpackage

// File: rtl/vcid_alloc.sv
module vcid_alloc
    import vcid_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc_en,
    input  logic  free_en,
    input  slot_t free_idx,
    output logic  any_free,
    output slot_t alloc_idx,
    output logic  free_hit,
    output cnt_t  free_cnt
);
    logic [NSLOT-1:0] busy;

    always_comb begin
        alloc_idx = '0;
        any_free  = 1'b0;
        for (int i = int'(NSLOT) - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                alloc_idx = slot_t'(i);
                any_free  = 1'b1;
            end
        end
    end

    assign free_hit = free_en && busy[free_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= '0;
            free_cnt <= cnt_t'(NSLOT);
        end else if (alloc_en && any_free) begin
            busy[alloc_idx] <= 1'b1;
            free_cnt        <= free_cnt - cnt_t'(1);
        end else if (free_hit) begin
            busy[free_idx] <= 1'b0;
            free_cnt       <= free_cnt + cnt_t'(1);
        end
    end

    // R7
    cnt_match_chk: assert property (@(posedge clk) disable iff (rst)
        int'(free_cnt) == int'(NSLOT) - $countones(busy));

    // R6
    no_alloc_full_chk: assert property (@(posedge clk) disable iff (rst)
        (free_cnt == '0) |-> !any_free);
endmodule

// File: rtl/vcid_regfile.sv
module vcid_regfile
    import vcid_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  slot_t wr_idx,
    input  vcid_t wr_data,
    input  slot_t rd_idx,
    output vcid_t rd_data
);
    vcid_t mem [NSLOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NSLOT); i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

    // R3
    wr_land_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/vcid_cmp.sv
module vcid_cmp
    import vcid_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  vcid_t a,
    input  vcid_t b,
    output logic  vld,
    output rel_e  rel,
    output logic  race
);
    logic [NTHR-1:0] le, ge;
    rel_e rel_d;

    for (genvar k = 0; k < int'(NTHR); k++) begin : g_lane
        assign le[k] = a[k*CW +: CW] <= b[k*CW +: CW];
        assign ge[k] = a[k*CW +: CW] >= b[k*CW +: CW];
    end

    always_comb begin
        if (&le && &ge) rel_d = REL_EQ;
        else if (&le)   rel_d = REL_BEFORE;
        else if (&ge)   rel_d = REL_AFTER;
        else            rel_d = REL_UNORD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            rel  <= REL_EQ;
            race <= 1'b0;
        end else begin
            vld <= req;
            if (req) begin
                rel  <= rel_d;
                race <= (rel_d == REL_UNORD);
            end
        end
    end

    // R4
    cmp_due_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> vld && rel == vc_rel($past(a), $past(b)));

    // R5
    race_code_chk: assert property (@(posedge clk) disable iff (rst)
        vld |-> (race == (rel == REL_UNORD)));
endmodule

// File: rtl/vcid_unit.sv
module vcid_unit
    import vcid_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [TW-1:0]       self_tid,
    input  logic [1:0]          op,
    input  logic [SW-1:0]       free_idx,
    input  logic [IDW-1:0]      mrg_id,
    input  logic [CNTW-1:0]     lwm,
    input  logic                cmp_req,
    input  logic [SW-1:0]       cmp_idx,
    input  logic [IDW-1:0]      cmp_id,
    output logic                stall,
    output logic [IDW-1:0]      cur_id,
    output logic [SW-1:0]       cur_slot,
    output logic                cur_vld,
    output logic [CNTW-1:0]     free_cnt,
    output logic                low_water,
    output logic                cmp_vld,
    output logic [1:0]          cmp_rel,
    output logic                cmp_race
);
    op_e   cmd;
    logic  any_free, free_hit, new_go, merge_go, free_go;
    slot_t alloc_idx;
    vcid_t succ_id, merged_id, rd_data;
    logic  wr_en;
    slot_t wr_idx;
    vcid_t wr_data;
    rel_e  rel_q;

    assign cmd      = op_e'(op);
    assign new_go   = (cmd == OP_NEW) && any_free;
    assign merge_go = (cmd == OP_MERGE);
    assign free_go  = (cmd == OP_FREE);
    assign stall    = (cmd == OP_NEW) && !any_free;

    assign succ_id   = vc_succ(cur_id, self_tid);
    assign merged_id = vc_merge(cur_id, mrg_id, self_tid);

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = alloc_idx;
        wr_data = succ_id;
        if (new_go) begin
            wr_en = 1'b1;
        end else if (merge_go && cur_vld) begin
            wr_en   = 1'b1;
            wr_idx  = cur_slot;
            wr_data = merged_id;
        end
    end

    vcid_alloc u_alloc (
        .clk      (clk),
        .rst      (rst),
        .alloc_en (new_go),
        .free_en  (free_go),
        .free_idx (free_idx),
        .any_free (any_free),
        .alloc_idx(alloc_idx),
        .free_hit (free_hit),
        .free_cnt (free_cnt)
    );

    vcid_regfile u_rf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .rd_idx (cmp_idx),
        .rd_data(rd_data)
    );

    vcid_cmp u_cmp (
        .clk (clk),
        .rst (rst),
        .req (cmp_req),
        .a   (rd_data),
        .b   (cmp_id),
        .vld (cmp_vld),
        .rel (rel_q),
        .race(cmp_race)
    );

    assign cmp_rel = rel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_id   <= '0;
            cur_slot <= '0;
            cur_vld  <= 1'b0;
        end else if (new_go) begin
            cur_id   <= succ_id;
            cur_slot <= alloc_idx;
            cur_vld  <= 1'b1;
        end else if (merge_go) begin
            cur_id <= merged_id;
        end else if (free_hit && cur_vld && free_idx == cur_slot) begin
            cur_vld <= 1'b0;
        end
    end

    assign low_water = free_cnt < lwm;

    // R2
    new_succ_chk: assert property (@(posedge clk) disable iff (rst)
        new_go |=> vc_rel($past(cur_id), cur_id) == REL_BEFORE && cur_vld
                   && free_cnt == $past(free_cnt) - cnt_t'(1));

    // R3
    merge_dom_chk: assert property (@(posedge clk) disable iff (rst)
        merge_go |=> vc_rel($past(mrg_id), cur_id) == REL_BEFORE
                     && vc_rel($past(cur_id), cur_id) == REL_BEFORE);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(cur_id) && $stable(cur_slot) && $stable(free_cnt));

    // R7
    free_up_chk: assert property (@(posedge clk) disable iff (rst)
        free_hit |=> free_cnt == $past(free_cnt) + cnt_t'(1));
endmodule

// File: tb/tb_vcid_unit.sv
module tb_vcid_unit;
    import vcid_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst;
    logic [TW-1:0]     self_tid;
    logic [1:0]        op;
    logic [SW-1:0]     free_idx;
    logic [IDW-1:0]    mrg_id;
    logic [CNTW-1:0]   lwm;
    logic              cmp_req;
    logic [SW-1:0]     cmp_idx;
    logic [IDW-1:0]    cmp_id;
    logic              stall;
    logic [IDW-1:0]    cur_id;
    logic [SW-1:0]     cur_slot;
    logic              cur_vld;
    logic [CNTW-1:0]   free_cnt;
    logic              low_water;
    logic              cmp_vld;
    logic [1:0]        cmp_rel;
    logic              cmp_race;

    vcid_unit dut (.*);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errs = 0;
    int checks = 0;

    typedef struct {
        int           due;
        int           what;
        logic [127:0] exp;
        string        req;
    } item_t;
    item_t sbq[$];

    // bench model
    logic [IDW-1:0] m_cur;
    logic [IDW-1:0] m_slot [NSLOT];
    bit             m_busy [NSLOT];
    int             m_cs;
    bit             m_vld;
    int             m_cnt;

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [127:0] actual(int what);
        case (what)
            0: return 128'(cur_id);
            1: return 128'(cur_slot);
            2: return 128'(cur_vld);
            3: return 128'(free_cnt);
            4: return 128'(cmp_rel);
            5: return 128'(cmp_race);
            default: return 128'(cmp_vld);
        endcase
    endfunction

    task automatic push(int what, logic [127:0] exp, string req);
        item_t it;
        it.due = cyc + 1;
        it.what = what;
        it.exp = exp;
        it.req = req;
        sbq.push_back(it);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sbq.size() > 0 && sbq[0].due <= cyc) begin
                item_t it;
                it = sbq.pop_front();
                if (it.due < cyc) begin
                    checks++;
                    errs++;
                    $display("FAIL %s: result missed, actual=none expected=%0h", it.req, it.exp);
                end else begin
                    chk(it.req, actual(it.what), it.exp);
                end
            end
        end
    end

    function automatic logic [IDW-1:0] mk(int c0, int c1, int c2, int c3);
        logic [IDW-1:0] v;
        v = '0;
        v[0*CW +: CW] = CW'(c0);
        v[1*CW +: CW] = CW'(c1);
        v[2*CW +: CW] = CW'(c2);
        v[3*CW +: CW] = CW'(c3);
        return v;
    endfunction

    function automatic int b_rel(logic [IDW-1:0] a, logic [IDW-1:0] b);
        bit le = 1, ge = 1;
        for (int k = 0; k < int'(NTHR); k++) begin
            if (a[k*CW +: CW] > b[k*CW +: CW]) le = 0;
            if (a[k*CW +: CW] < b[k*CW +: CW]) ge = 0;
        end
        if (le && ge) return 0;
        if (le) return 1;
        if (ge) return 2;
        return 3;
    endfunction

    task automatic do_new();
        @(negedge clk);
        op = 2'd1;
        #1;
        chk("R6 stall", 128'(stall), 128'(m_cnt == 0));
        chk("R8 low_water", 128'(low_water), 128'(m_cnt < int'(lwm)));
        if (m_cnt > 0) begin
            int k;
            k = 0;
            while (m_busy[k]) k++;
            m_cur[int'(self_tid)*CW +: CW] = m_cur[int'(self_tid)*CW +: CW] + CW'(1);
            m_slot[k] = m_cur;
            m_busy[k] = 1;
            m_cs = k;
            m_vld = 1;
            m_cnt--;
            push(0, 128'(m_cur), "R2 cur_id");
            push(1, 128'(m_cs), "R2 cur_slot");
            push(2, 128'(1), "R2 cur_vld");
            push(3, 128'(m_cnt), "R2 free_cnt");
        end else begin
            push(0, 128'(m_cur), "R6 cur_id held");
            push(1, 128'(m_cs), "R6 cur_slot held");
            push(3, 128'(0), "R6 free_cnt held");
        end
        @(negedge clk);
        op = 2'd0;
    endtask

    task automatic do_merge(logic [IDW-1:0] id, string req);
        @(negedge clk);
        op = 2'd2;
        mrg_id = id;
        for (int k = 0; k < int'(NTHR); k++)
            if (id[k*CW +: CW] > m_cur[k*CW +: CW]) m_cur[k*CW +: CW] = id[k*CW +: CW];
        m_cur[int'(self_tid)*CW +: CW] = m_cur[int'(self_tid)*CW +: CW] + CW'(1);
        if (m_vld) m_slot[m_cs] = m_cur;
        push(0, 128'(m_cur), req);
        @(negedge clk);
        op = 2'd0;
    endtask

    task automatic do_free(int idx);
        @(negedge clk);
        op = 2'd3;
        free_idx = SW'(idx);
        if (m_busy[idx]) begin
            m_busy[idx] = 0;
            m_cnt++;
            if (m_vld && m_cs == idx) m_vld = 0;
        end
        push(3, 128'(m_cnt), "R7 free_cnt");
        push(2, 128'(m_vld), "R7 cur_vld");
        @(negedge clk);
        op = 2'd0;
    endtask

    task automatic do_cmp(int idx, logic [IDW-1:0] id, string req);
        int r;
        @(negedge clk);
        cmp_req = 1'b1;
        cmp_idx = SW'(idx);
        cmp_id = id;
        r = b_rel(m_slot[idx], id);
        push(6, 128'(1), "R4 cmp_vld");
        push(4, 128'(r), req);
        push(5, 128'(r == 3), "R5 cmp_race");
        @(negedge clk);
        cmp_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        self_tid = 2'd1;
        op = 2'd0;
        free_idx = '0;
        mrg_id = '0;
        lwm = CNTW'(4);
        cmp_req = 1'b0;
        cmp_idx = '0;
        cmp_id = '0;
        m_cur = '0;
        m_cs = 0;
        m_vld = 0;
        m_cnt = NSLOT;
        for (int i = 0; i < int'(NSLOT); i++) begin
            m_slot[i] = '0;
            m_busy[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 cur_vld", 128'(cur_vld), 128'(0));
        chk("R1 cur_id", 128'(cur_id), 128'(0));
        chk("R1 free_cnt", 128'(free_cnt), 128'(NSLOT));
        chk("R1 stall", 128'(stall), 128'(0));
        chk("R1 cmp_vld", 128'(cmp_vld), 128'(0));

        do_new();
        do_new();
        do_new();

        do_cmp(0, m_cur, "R4 before");
        do_cmp(2, m_cur, "R4 equal");
        do_cmp(0, '0, "R4 after");
        do_cmp(2, mk(5, 2, 0, 0), "R5 unordered");

        do_merge(mk(7, 1, 4, 0), "R3 merge");
        do_cmp(m_cs, mk(7, 1, 4, 0), "R3 slot rewritten after");

        do_merge(mk(0, 0, 9, 0), "R9 barrier merge 1");
        do_merge(mk(0, 0, 0, 12), "R9 barrier merge 2");
        do_cmp(m_cs, mk(0, 0, 9, 0), "R9 after id 1");
        do_cmp(m_cs, mk(0, 0, 0, 12), "R9 after id 2");

        do_free(1);
        do_new();
        do_free(5);

        self_tid = 2'd3;
        while (m_cnt > 0) do_new();
        do_new();

        do_free(m_cs);
        do_new();

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule